// File: doc/BRIEF.md
# UART FIFO Control and Interrupt Status Unit

This block is the register-side front end of a 16550-style serial port. A host writes a write-only FIFO control byte. From that byte the block keeps the FIFO enable state and a transmit trigger level. It also issues one-cycle pointer-reset pulses to the separate transmit and receive FIFOs.

The block also builds the readable interrupt status byte. The upper two bits mirror the FIFO enable state. Bits 5 and 4 flag flow-control and received-character match events, and both need the enhanced-feature bit. Bits 3:1 hold a prioritised source code, and bit 0 is low while any source is pending.

The transmit interrupt request comes from the transmit FIFO fill count and the selected trigger level. It is raised in two cases: when the count drops below the level, and when the FIFO drains to empty without having gone above the level since it was last empty.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the FIFOs are disabled, the reported trigger level is 1, tx_irq, rx_fifo_clr and tx_fifo_clr are low, and stat_byte reads 8'h01.
- R2: A control write with bit 0 = 0 disables the FIFOs. It produces no reset pulse and leaves the stored trigger code unchanged, which shows when the FIFOs are enabled again. While the FIFOs are disabled the reported level is 1.
- R3: A control write with bit 0 = 1 enables the FIFOs. If bit 1 is set, rx_fifo_clr is high for exactly the one cycle after the write. If bit 2 is set, tx_fifo_clr is high for exactly the one cycle after the write. Bit 3 has no effect.
- R4: Control bits 5:4 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. They are stored only when the same write has bit 0 = 1 and enh_en = 1.
- R5: stat_byte[7:6] reads 2'b11 while the FIFOs are enabled and 2'b00 while they are disabled.
- R6: tx_irq rises in the cycle after tx_count goes from at least the level to below it.
- R7: tx_irq also rises when tx_count drops to 0, but only if the count stayed at or below the level since it was last 0.
- R8: tx_irq clears when tx_count increases, or when a status read strobe occurs while the status code reports the transmit source.
- R9: With enh_en = 1, a pulse on xoff_hit sets stat_byte[4]. A status read clears it.
- R10: With enh_en = 1, a pulse on spec_hit sets stat_byte[4]. It clears on a status read or on the next rx_char pulse.
- R11: With enh_en = 1, a pulse on flow_deassert sets stat_byte[5]. A status read clears it.
- R12: The source codes in stat_byte[3:1] are, in falling priority: line status 3'b011, receive data 3'b010, transmit 3'b001, flow/character events 3'b000. stat_byte[0] is 0 when any source is pending, and otherwise it is 1 with [3:1] = 000.
- R13: An event that arrives in the same cycle as a status read sets its flag, and the read does not clear it.
- R14: While enh_en = 0, stat_byte[5:4] read 0, match and flow events set nothing, and these events do not count as pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the FIFO control byte |
| wdata | input | 8 | Control byte write data |
| stat_rd | input | 1 | Single-cycle status read strobe |
| enh_en | input | 1 | Enhanced-feature enable |
| tx_count | input | 5 | Transmit FIFO fill count |
| line_err | input | 1 | Receive line status interrupt pending |
| rx_avail | input | 1 | Receive data interrupt pending |
| rx_char | input | 1 | Pulse: a character was received |
| xoff_hit | input | 1 | Pulse: Xoff character matched |
| spec_hit | input | 1 | Pulse: special character matched |
| flow_deassert | input | 1 | Pulse: CTS# or RTS# deasserted |
| rx_fifo_clr | output | 1 | Receive FIFO pointer/level reset pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO pointer/level reset pulse |
| tx_trig_lvl | output | 5 | Active transmit trigger level |
| tx_irq | output | 1 | Transmit interrupt request |
| stat_byte | output | 8 | Interrupt status byte |

## Verification
The assertions assume three things about the inputs. The match and flow inputs are single-cycle pulses. line_err and rx_avail are levels that hold for whole cycles. tx_count never exceeds the FIFO depth. The bench drives every input on the falling clock edge and keeps each event to a single cycle. Its fill counts stay between 0 and 6, well within a depth of 16. It raises line_err and rx_avail only in the priority test, and there it holds them across whole cycles.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef enum logic [2:0] {
        SRC_FLOW = 3'b000,
        SRC_TX   = 3'b001,
        SRC_RXD  = 3'b010,
        SRC_LINE = 3'b011
    } src_e;

    typedef struct packed {
        logic       fifo_en;
        logic [1:0] code;
        logic       rx_clr;
        logic       tx_clr;
    } ctl_st_t;

    typedef struct packed {
        logic xoff;
        logic spec;
        logic flow;
    } flag_st_t;

endpackage

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       en_bit,
    input  logic       rxc_bit,
    input  logic       txc_bit,
    input  logic [1:0] code_bits,
    input  logic       enh_en,
    output logic       fifo_en,
    output logic [1:0] trig_code,
    output logic       rx_clr,
    output logic       tx_clr
);

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rx_clr = 1'b0;
        st_d.tx_clr = 1'b0;
        if (ctl_wr) begin
            if (en_bit) begin
                st_d.fifo_en = 1'b1;
                st_d.rx_clr  = rxc_bit;
                st_d.tx_clr  = txc_bit;
                if (enh_en) begin
                    st_d.code = code_bits;
                end
            end else begin
                st_d.fifo_en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_en   = st_q.fifo_en;
    assign trig_code = st_q.code;
    assign rx_clr    = st_q.rx_clr;
    assign tx_clr    = st_q.tx_clr;

endmodule

// File: rtl/ufc_tx_irq.sv
module ufc_tx_irq #(
    parameter int DEPTH = 16,
    parameter int LVL1  = 4,
    parameter int LVL2  = 8,
    parameter int LVL3  = 14,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_code,
    input  logic [CW-1:0] tx_count,
    input  logic          ack,
    output logic [CW-1:0] level,
    output logic          irq
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          above;
        logic          irq;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    fall_below;
    logic    drained;
    logic    refill;

    always_comb begin
        if (!fifo_en) begin
            level = CW'(1);
        end else begin
            unique case (trig_code)
                2'b01:   level = CW'(LVL1);
                2'b10:   level = CW'(LVL2);
                2'b11:   level = CW'(LVL3);
                default: level = CW'(1);
            endcase
        end
    end

    always_comb begin
        fall_below = (st_q.cnt >= level) && (tx_count < level);
        drained    = (st_q.cnt != '0) && (tx_count == '0) && !st_q.above;
        refill     = tx_count > st_q.cnt;

        st_d     = st_q;
        st_d.cnt = tx_count;

        if (tx_count == '0) begin
            st_d.above = 1'b0;
        end else if (tx_count > level) begin
            st_d.above = 1'b1;
        end

        if (fall_below || drained) begin
            st_d.irq = 1'b1;
        end else if (refill || ack) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/ufc_status.sv
module ufc_status
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enh_en,
    input  logic       fifo_en,
    input  logic       stat_rd,
    input  logic       rx_char,
    input  logic       xoff_hit,
    input  logic       spec_hit,
    input  logic       flow_deassert,
    input  logic       line_err,
    input  logic       rx_avail,
    input  logic       tx_irq,
    output logic [7:0] stat_byte,
    output logic       tx_ack
);

    flag_st_t fl_d, fl_q;
    src_e     src;
    logic     pending;
    logic     match_vis;
    logic     flow_vis;

    assign match_vis = enh_en && (fl_q.xoff || fl_q.spec);
    assign flow_vis  = enh_en && fl_q.flow;

    always_comb begin
        pending = 1'b1;
        if (line_err) begin
            src = SRC_LINE;
        end else if (rx_avail) begin
            src = SRC_RXD;
        end else if (tx_irq) begin
            src = SRC_TX;
        end else begin
            src     = SRC_FLOW;
            pending = match_vis || flow_vis;
        end
    end

    always_comb begin
        fl_d = fl_q;
        if (enh_en && xoff_hit) begin
            fl_d.xoff = 1'b1;
        end else if (stat_rd) begin
            fl_d.xoff = 1'b0;
        end
        if (enh_en && spec_hit) begin
            fl_d.spec = 1'b1;
        end else if (stat_rd || rx_char) begin
            fl_d.spec = 1'b0;
        end
        if (enh_en && flow_deassert) begin
            fl_d.flow = 1'b1;
        end else if (stat_rd) begin
            fl_d.flow = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign stat_byte = {{2{fifo_en}}, flow_vis, match_vis,
                        pending ? src : SRC_FLOW, !pending};
    assign tx_ack    = stat_rd && pending && (src == SRC_TX);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
    parameter int DEPTH = 16,
    parameter int LVL1  = 4,
    parameter int LVL2  = 8,
    parameter int LVL3  = 14,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [7:0]    wdata,
    input  logic          stat_rd,
    input  logic          enh_en,
    input  logic [CW-1:0] tx_count,
    input  logic          line_err,
    input  logic          rx_avail,
    input  logic          rx_char,
    input  logic          xoff_hit,
    input  logic          spec_hit,
    input  logic          flow_deassert,
    output logic          rx_fifo_clr,
    output logic          tx_fifo_clr,
    output logic [CW-1:0] tx_trig_lvl,
    output logic          tx_irq,
    output logic [7:0]    stat_byte
);

    logic       fifo_en;
    logic [1:0] trig_code;
    logic       tx_ack;
    logic       unused_bits;

    assign unused_bits = ^{wdata[7:6], wdata[3]};

    ufc_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .en_bit    (wdata[0]),
        .rxc_bit   (wdata[1]),
        .txc_bit   (wdata[2]),
        .code_bits (wdata[5:4]),
        .enh_en    (enh_en),
        .fifo_en   (fifo_en),
        .trig_code (trig_code),
        .rx_clr    (rx_fifo_clr),
        .tx_clr    (tx_fifo_clr)
    );

    ufc_tx_irq #(
        .DEPTH (DEPTH),
        .LVL1  (LVL1),
        .LVL2  (LVL2),
        .LVL3  (LVL3)
    ) u_txi (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .trig_code (trig_code),
        .tx_count  (tx_count),
        .ack       (tx_ack),
        .level     (tx_trig_lvl),
        .irq       (tx_irq)
    );

    ufc_status u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .enh_en        (enh_en),
        .fifo_en       (fifo_en),
        .stat_rd       (stat_rd),
        .rx_char       (rx_char),
        .xoff_hit      (xoff_hit),
        .spec_hit      (spec_hit),
        .flow_deassert (flow_deassert),
        .line_err      (line_err),
        .rx_avail      (rx_avail),
        .tx_irq        (tx_irq),
        .stat_byte     (stat_byte),
        .tx_ack        (tx_ack)
    );

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic          rx_req,
    input logic          tx_req,
    input logic          enh_en,
    input logic          line_err,
    input logic          rx_fifo_clr,
    input logic          tx_fifo_clr,
    input logic [CW-1:0] tx_trig_lvl,
    input logic [7:0]    stat_byte
);

    assert_rx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_clr |=> !rx_fifo_clr);

    assert_tx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_clr |=> !tx_fifo_clr);

    assert_rx_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_clr |-> $past(rx_req));

    assert_tx_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_clr |-> $past(tx_req));

    assert_lvl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(tx_trig_lvl));

    assert_en_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[7] == stat_byte[6]);

    assert_idle_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[0] |-> (stat_byte[3:1] == 3'b000));

    assert_line_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |-> (stat_byte[3:0] == 4'b0110));

    assert_enh_mask_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en |-> (stat_byte[5:4] == 2'b00));

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .rx_req      (ctl_wr & wdata[0] & wdata[1]),
    .tx_req      (ctl_wr & wdata[0] & wdata[2]),
    .enh_en      (enh_en),
    .line_err    (line_err),
    .rx_fifo_clr (rx_fifo_clr),
    .tx_fifo_clr (tx_fifo_clr),
    .tx_trig_lvl (tx_trig_lvl),
    .stat_byte   (stat_byte)
);

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // entry: {wdata[7:0], enh, level[4:0], stat[7:6]}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'h01, 1'b1, 5'd1,  2'b11},
        {8'h11, 1'b1, 5'd4,  2'b11},
        {8'h21, 1'b1, 5'd8,  2'b11},
        {8'h31, 1'b0, 5'd8,  2'b11},
        {8'h30, 1'b1, 5'd1,  2'b00},
        {8'h01, 1'b0, 5'd8,  2'b11},
        {8'h39, 1'b1, 5'd14, 2'b11},
        {8'h01, 1'b1, 5'd1,  2'b11}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] wdata = '0;
    logic       stat_rd = 1'b0;
    logic       enh_en = 1'b0;
    logic [4:0] tx_count = '0;
    logic       line_err = 1'b0;
    logic       rx_avail = 1'b0;
    logic       rx_char = 1'b0;
    logic       xoff_hit = 1'b0;
    logic       spec_hit = 1'b0;
    logic       flow_deassert = 1'b0;
    logic       rx_fifo_clr, tx_fifo_clr, tx_irq;
    logic [4:0] tx_trig_lvl;
    logic [7:0] stat_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_fifo_ctl u_dut (
        .clk (clk), .rst_n (rst_n), .ctl_wr (ctl_wr), .wdata (wdata),
        .stat_rd (stat_rd), .enh_en (enh_en), .tx_count (tx_count),
        .line_err (line_err), .rx_avail (rx_avail), .rx_char (rx_char),
        .xoff_hit (xoff_hit), .spec_hit (spec_hit),
        .flow_deassert (flow_deassert), .rx_fifo_clr (rx_fifo_clr),
        .tx_fifo_clr (tx_fifo_clr), .tx_trig_lvl (tx_trig_lvl),
        .tx_irq (tx_irq), .stat_byte (stat_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock: inputs already set at the falling edge, results sampled just after the rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_edge();
        @(negedge clk);
        ctl_wr = 0; stat_rd = 0; rx_char = 0; xoff_hit = 0;
        spec_hit = 0; flow_deassert = 0;
    endtask

    task automatic wr(input logic [7:0] d, input logic e);
        @(negedge clk);
        ctl_wr = 1; wdata = d; enh_en = e;
        tick();
        idle_edge();
    endtask

    task automatic cnt(input int c);
        @(negedge clk);
        tx_count = 5'(c);
        tick();
    endtask

    task automatic rd();
        @(negedge clk);
        stat_rd = 1;
        tick();
        idle_edge();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 stat", 32'(stat_byte), 32'h01);
        chk("R1 lvl", 32'(tx_trig_lvl), 32'd1);
        chk("R1 irq", 32'(tx_irq), 32'd0);
        chk("R1 clr", 32'({rx_fifo_clr, tx_fifo_clr}), 32'd0);

        // R2/R4/R5 control writes from the table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            ctl_wr = 1; wdata = VEC[i][15:8]; enh_en = VEC[i][7];
            tick();
            chk("R4 level", 32'(tx_trig_lvl), 32'(VEC[i][6:2]));
            chk("R5 enable bits", 32'(stat_byte[7:6]), 32'(VEC[i][1:0]));
            chk("R2 no pulse", 32'({rx_fifo_clr, tx_fifo_clr}), 32'd0);
            idle_edge();
        end

        // R3 reset pulses
        @(negedge clk); ctl_wr = 1; wdata = 8'h03; enh_en = 1;
        tick();
        chk("R3 rx pulse", 32'({rx_fifo_clr, tx_fifo_clr}), 32'b10);
        idle_edge(); tick();
        chk("R3 rx one cycle", 32'({rx_fifo_clr, tx_fifo_clr}), 32'b00);
        @(negedge clk); ctl_wr = 1; wdata = 8'h05;
        tick();
        chk("R3 tx pulse", 32'({rx_fifo_clr, tx_fifo_clr}), 32'b01);
        idle_edge(); tick();
        chk("R3 tx one cycle", 32'({rx_fifo_clr, tx_fifo_clr}), 32'b00);
        @(negedge clk); ctl_wr = 1; wdata = 8'h06;
        tick();
        chk("R2 gated pulses", 32'({rx_fifo_clr, tx_fifo_clr}), 32'b00);
        chk("R2 disabled", 32'(stat_byte), 32'h01);
        idle_edge();

        // R6 below-trigger with level 4
        wr(8'h11, 1);
        chk("R4 level 4", 32'(tx_trig_lvl), 32'd4);
        cnt(6); cnt(5); cnt(4);
        chk("R6 not yet", 32'(tx_irq), 32'd0);
        cnt(3);
        chk("R6 below trigger", 32'(tx_irq), 32'd1);
        chk("R12 tx code", 32'(stat_byte), 32'hC2);
        rd(); #1;
        chk("R8 read clears", 32'(tx_irq), 32'd0);
        // R7 no empty event after exceeding the level
        cnt(0);
        chk("R7 no empty irq", 32'(tx_irq), 32'd0);
        cnt(3); cnt(2); cnt(1);
        chk("R7 quiet while under", 32'(tx_irq), 32'd0);
        cnt(0);
        chk("R7 empty irq", 32'(tx_irq), 32'd1);
        cnt(2);
        chk("R8 refill clears", 32'(tx_irq), 32'd0);
        chk("R1 idle enabled", 32'(stat_byte), 32'hC1);

        // R9 Xoff match
        @(negedge clk); xoff_hit = 1; tick(); idle_edge(); #1;
        chk("R9 xoff set", 32'(stat_byte), 32'hD0);
        rd(); #1;
        chk("R9 read clears", 32'(stat_byte), 32'hC1);

        // R10 special char
        @(negedge clk); spec_hit = 1; tick(); idle_edge(); #1;
        chk("R10 spec set", 32'(stat_byte[4]), 32'd1);
        @(negedge clk); rx_char = 1; tick(); idle_edge(); #1;
        chk("R10 next char clears", 32'(stat_byte[4]), 32'd0);
        @(negedge clk); spec_hit = 1; tick(); idle_edge();
        rd(); #1;
        chk("R10 read clears", 32'(stat_byte[4]), 32'd0);

        // R11 flow event, R13 same-cycle read
        @(negedge clk); flow_deassert = 1; tick(); idle_edge(); #1;
        chk("R11 flow set", 32'(stat_byte), 32'hE0);
        rd(); #1;
        chk("R11 read clears", 32'(stat_byte[5]), 32'd0);
        @(negedge clk); flow_deassert = 1; stat_rd = 1; tick(); idle_edge(); #1;
        chk("R13 flag kept", 32'(stat_byte[5]), 32'd1);
        rd(); #1;
        chk("R13 later read", 32'(stat_byte[5]), 32'd0);

        // R12 priority
        @(negedge clk); line_err = 1; rx_avail = 1; #1;
        chk("R12 line first", 32'(stat_byte[3:0]), 32'h6);
        @(negedge clk); line_err = 0; #1;
        chk("R12 rx data", 32'(stat_byte[3:0]), 32'h4);
        @(negedge clk); rx_avail = 0;
        cnt(0);
        @(negedge clk); flow_deassert = 1; tick(); idle_edge(); #1;
        chk("R12 tx over flow", 32'(stat_byte[3:0]), 32'h2);
        rd(); #1;
        chk("R8 read at tx", 32'(tx_irq), 32'd0);
        @(negedge clk); flow_deassert = 1; tick(); idle_edge(); #1;
        chk("R12 flow code", 32'(stat_byte[3:0]), 32'h0);
        rd();

        // R14 enhanced off
        @(negedge clk); xoff_hit = 1; tick(); idle_edge(); #1;
        @(negedge clk); enh_en = 0; #1;
        chk("R14 masked", 32'(stat_byte), 32'hC1);
        @(negedge clk); enh_en = 1; #1;
        rd(); #1;
        @(negedge clk); enh_en = 0; flow_deassert = 1; spec_hit = 1; tick(); idle_edge();
        @(negedge clk); enh_en = 1; #1;
        chk("R14 events ignored", 32'(stat_byte), 32'hC1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule